// File: doc/BRIEF.md
# Host Memory Request Address Router

This block sits on the host side of the memory path and decides, for each incoming memory request, where it goes: to DRAM, to the downstream legacy I/O link, or down an invalid-cycle path. It protects the system-management memory segment (TSEG) from requests that should not reach it, and it can open a one-megabyte legacy window just below the 16 MB line that sends requests to the legacy link instead of DRAM.

The TSEG window is derived from configuration values: the top of low usable memory, two stolen-memory sizes and the TSEG size. Its base and limit are held in a register that is reloaded by a load strobe. Each request is decided in one registered stage. Blocked requests from non-processor requesters are changed to a harmless dummy access before they leave the block. Blocked processor requests are only flagged.

Top module: `mem_req_router`

## Requirements
- R1: After reset `out_valid` is 0. Each request presented with `req_valid` high appears on the outputs exactly one clock later with `out_valid` high. A cycle without a request gives `out_valid` low one clock later. `out_invalid` is high exactly when `out_dest` is 2.
- R2: On a clock edge where `cfg_load` is high, the TSEG limit becomes `cfg_tolud - cfg_dsm_size - cfg_gsm_size` and the base becomes that limit minus `cfg_tseg_size`. A request sampled on the very next edge uses the new window. Changes to these four inputs while `cfg_load` is low have no effect on routing.
- R3: When the hole enable is set, a request that is not graphics-translated and falls in [0xF0_0000, 0x100_0000) goes to the legacy link (`out_dest` = 1), with its address and byte enables unchanged.
- R4: Addresses outside both windows go to DRAM (`out_dest` = 0). So do hole addresses when the hole enable is clear. In both cases the address and byte enables are unchanged.
- R5: A graphics-translated request inside the hole range goes to DRAM, whatever the hole enable says.
- R6: A processor request (`req_src` = 0) inside an enabled TSEG window goes to DRAM at the same address in two cases: when it carries the system-management attribute and the write-back attribute, or when extended system-management space is disabled.
- R7: With extended system-management space enabled, a processor request inside an enabled TSEG window that lacks the system-management attribute or the write-back attribute goes out with `out_dest` = 2. Its address and byte enables are unchanged.
- R8: A request from PCIe (1), the legacy link (2) or integrated graphics (3) inside an enabled TSEG window goes out with `out_dest` = 2 and address 0xC_0000. Its byte enables become all zero for a write and stay unchanged for a read.
- R9: With the TSEG enable clear, no address is treated as TSEG, and requests in the window follow the hole and DRAM rules.
- R10: Where the TSEG window and the hole overlap, the TSEG rules take precedence over the hole rule. Window bounds are inclusive at the base and exclusive at the limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Reload the TSEG window from the four size inputs |
| cfg_tolud | input | 36 | Top of low usable memory |
| cfg_dsm_size | input | 36 | Data stolen-memory size |
| cfg_gsm_size | input | 36 | Translation-table stolen-memory size |
| cfg_tseg_size | input | 36 | TSEG size |
| cfg_tseg_en | input | 1 | TSEG protection enable |
| cfg_ext_smram_en | input | 1 | Extended system-management space enable |
| cfg_hole_en | input | 1 | Legacy 15–16 MB hole enable |
| req_valid | input | 1 | Request present |
| req_addr | input | 36 | Request physical address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | 8 | Request byte enables |
| req_src | input | 2 | Requester: 0 processor, 1 PCIe, 2 legacy link, 3 graphics |
| req_gfx_xlat | input | 1 | Graphics-translated request |
| req_smm | input | 1 | System-management attribute |
| req_wb | input | 1 | Write-back attribute |
| out_valid | output | 1 | Routed request present |
| out_dest | output | 2 | 0 DRAM, 1 legacy link, 2 invalid |
| out_addr | output | 36 | Possibly rewritten address |
| out_be | output | 8 | Possibly cleared byte enables |
| out_invalid | output | 1 | Request was blocked |

## Verification
The main sweep sends every combination of requester, direction, graphics-translated flag, both attributes and all three enables. These go to the addresses one below, at, one below the end of, and at the end of the TSEG window and of the hole. That shows the inclusive and exclusive bounds and separates the processor checks from the non-processor rewrite. A second configuration puts TSEG exactly over the hole, which shows the order in which the two checks apply. A reload sequence first changes the size inputs without the strobe and then pulses the strobe, which tells a held window from a live one and confirms that the new window is in use on the next cycle.

// File: rtl/mrr_pkg.sv
package mrr_pkg;
    typedef enum logic [1:0] {
        DEST_DRAM    = 2'd0,
        DEST_LINK    = 2'd1,
        DEST_INVALID = 2'd2
    } dest_e;

    typedef enum logic [1:0] {
        SRC_CPU  = 2'd0,
        SRC_PCIE = 2'd1,
        SRC_LINK = 2'd2,
        SRC_GFX  = 2'd3
    } src_e;
endpackage

// File: rtl/mrr_tseg_window.sv
module mrr_tseg_window #(
    parameter int AW = 36
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_load,
    input  logic [AW-1:0] tolud,
    input  logic [AW-1:0] dsm_size,
    input  logic [AW-1:0] gsm_size,
    input  logic [AW-1:0] tseg_size,
    output logic [AW-1:0] win_base,
    output logic [AW-1:0] win_limit
);
    typedef struct packed {
        logic [AW-1:0] base;
        logic [AW-1:0] limit;
    } win_t;

    win_t win_d, win_q;

    always_comb begin
        win_d = win_q;
        if (cfg_load) begin
            win_d.limit = tolud - dsm_size - gsm_size;
            win_d.base  = win_d.limit - tseg_size;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_d;
    end

    assign win_base  = win_q.base;
    assign win_limit = win_q.limit;

    // Window is held between load strobes (R2)
    assert_window_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_load |=> $stable(win_q));

    // Window span after a load equals the TSEG size input (R2)
    assert_window_span_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |=> (win_limit - win_base) == $past(tseg_size));
endmodule

// File: rtl/mrr_range_hit.sv
module mrr_range_hit #(
    parameter int AW = 36
) (
    input  logic          en,
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] lo,
    input  logic [AW-1:0] hi,
    output logic          hit
);
    always_comb begin
        hit = en && (addr >= lo) && (addr < hi);
    end
endmodule

// File: rtl/mrr_route_stage.sv
module mrr_route_stage
    import mrr_pkg::*;
#(
    parameter int          AW         = 36,
    parameter int          BE_W       = 8,
    parameter logic [AW-1:0] DUMMY_ADDR = 36'h0_000C_0000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [AW-1:0]   req_addr,
    input  logic            req_write,
    input  logic [BE_W-1:0] req_be,
    input  src_e            req_src,
    input  logic            req_gfx_xlat,
    input  logic            req_smm,
    input  logic            req_wb,
    input  logic            hole_en,
    input  logic            ext_smram_en,
    input  logic            hit_tseg,
    input  logic            hit_hole,
    output logic            out_valid,
    output dest_e           out_dest,
    output logic [AW-1:0]   out_addr,
    output logic [BE_W-1:0] out_be
);
    typedef struct packed {
        logic            valid;
        dest_e           dest;
        logic [AW-1:0]   addr;
        logic [BE_W-1:0] be;
        src_e            src;
        logic            wr;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.valid = 1'b0;
        if (req_valid) begin
            st_d.valid = 1'b1;
            st_d.src   = req_src;
            st_d.wr    = req_write;
            st_d.addr  = req_addr;
            st_d.be    = req_be;
            st_d.dest  = DEST_DRAM;
            if (hit_tseg) begin
                if (req_src == SRC_CPU) begin
                    if (ext_smram_en && (!req_smm || !req_wb))
                        st_d.dest = DEST_INVALID;
                end else begin
                    st_d.dest = DEST_INVALID;
                    st_d.addr = DUMMY_ADDR;
                    if (req_write) st_d.be = '0;
                end
            end else if (hit_hole) begin
                if (!req_gfx_xlat && hole_en) st_d.dest = DEST_LINK;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign out_dest  = st_q.dest;
    assign out_addr  = st_q.addr;
    assign out_be    = st_q.be;

    // One-cycle latency of the request (R1)
    assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);

    // Processor addresses are never rewritten (R6, R7)
    assert_cpu_addr_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_src == SRC_CPU) |=> out_addr == $past(req_addr));

    // Legacy link only reached from the hole (R3)
    assert_link_only_hole_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !hit_hole) |=> out_dest != DEST_LINK);

    // Blocked non-processor cycles are turned into the dummy access (R8)
    assert_dummy_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_dest == DEST_INVALID && st_q.src != SRC_CPU) |->
            (out_addr == DUMMY_ADDR) && (!st_q.wr || out_be == '0));

    // TSEG hits from non-processor requesters never reach DRAM or the link (R8, R10)
    assert_tseg_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && hit_tseg && req_src != SRC_CPU) |=> out_dest == DEST_INVALID);
endmodule

// File: rtl/mem_req_router.sv
module mem_req_router
    import mrr_pkg::*;
#(
    parameter int AW        = 36,
    parameter int BE_W      = 8,
    parameter logic [AW-1:0] HOLE_BASE  = 36'h0_00F0_0000,
    parameter logic [AW-1:0] HOLE_LIMIT = 36'h0_0100_0000,
    parameter logic [AW-1:0] DUMMY_ADDR = 36'h0_000C_0000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_load,
    input  logic [AW-1:0]   cfg_tolud,
    input  logic [AW-1:0]   cfg_dsm_size,
    input  logic [AW-1:0]   cfg_gsm_size,
    input  logic [AW-1:0]   cfg_tseg_size,
    input  logic            cfg_tseg_en,
    input  logic            cfg_ext_smram_en,
    input  logic            cfg_hole_en,
    input  logic            req_valid,
    input  logic [AW-1:0]   req_addr,
    input  logic            req_write,
    input  logic [BE_W-1:0] req_be,
    input  logic [1:0]      req_src,
    input  logic            req_gfx_xlat,
    input  logic            req_smm,
    input  logic            req_wb,
    output logic            out_valid,
    output logic [1:0]      out_dest,
    output logic [AW-1:0]   out_addr,
    output logic [BE_W-1:0] out_be,
    output logic            out_invalid
);
    localparam int N_WIN = 2;
    localparam int W_TSEG = 0;
    localparam int W_HOLE = 1;

    logic [AW-1:0] tseg_base, tseg_limit;
    logic [AW-1:0] win_lo [N_WIN];
    logic [AW-1:0] win_hi [N_WIN];
    logic          win_en [N_WIN];
    logic          win_hit [N_WIN];
    dest_e         dest_w;

    mrr_tseg_window #(.AW(AW)) u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_load  (cfg_load),
        .tolud     (cfg_tolud),
        .dsm_size  (cfg_dsm_size),
        .gsm_size  (cfg_gsm_size),
        .tseg_size (cfg_tseg_size),
        .win_base  (tseg_base),
        .win_limit (tseg_limit)
    );

    always_comb begin
        win_lo[W_TSEG] = tseg_base;
        win_hi[W_TSEG] = tseg_limit;
        win_en[W_TSEG] = cfg_tseg_en;
        win_lo[W_HOLE] = HOLE_BASE;
        win_hi[W_HOLE] = HOLE_LIMIT;
        win_en[W_HOLE] = 1'b1;
    end

    for (genvar gi = 0; gi < N_WIN; gi++) begin : g_win
        mrr_range_hit #(.AW(AW)) u_hit (
            .en   (win_en[gi]),
            .addr (req_addr),
            .lo   (win_lo[gi]),
            .hi   (win_hi[gi]),
            .hit  (win_hit[gi])
        );
    end

    mrr_route_stage #(.AW(AW), .BE_W(BE_W), .DUMMY_ADDR(DUMMY_ADDR)) u_route (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_addr     (req_addr),
        .req_write    (req_write),
        .req_be       (req_be),
        .req_src      (src_e'(req_src)),
        .req_gfx_xlat (req_gfx_xlat),
        .req_smm      (req_smm),
        .req_wb       (req_wb),
        .hole_en      (cfg_hole_en),
        .ext_smram_en (cfg_ext_smram_en),
        .hit_tseg     (win_hit[W_TSEG]),
        .hit_hole     (win_hit[W_HOLE]),
        .out_valid    (out_valid),
        .out_dest     (dest_w),
        .out_addr     (out_addr),
        .out_be       (out_be)
    );

    assign out_dest    = dest_w;
    assign out_invalid = (dest_w == DEST_INVALID);

    // Invalid flag never accompanies a DRAM or link destination (R1)
    assert_flag_dest_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_invalid |-> out_dest == 2'd2);

    // With TSEG disabled nothing is blocked (R9)
    assert_no_block_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !cfg_tseg_en) |=> !out_invalid);
endmodule

// File: tb/mem_req_router_tb.sv
module mem_req_router_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_load;
    logic [35:0] cfg_tolud, cfg_dsm_size, cfg_gsm_size, cfg_tseg_size;
    logic        cfg_tseg_en, cfg_ext_smram_en, cfg_hole_en;
    logic        req_valid;
    logic [35:0] req_addr;
    logic        req_write;
    logic [7:0]  req_be;
    logic [1:0]  req_src;
    logic        req_gfx_xlat, req_smm, req_wb;
    logic        out_valid;
    logic [1:0]  out_dest;
    logic [35:0] out_addr;
    logic [7:0]  out_be;
    logic        out_invalid;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mem_req_router u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load),
        .cfg_tolud(cfg_tolud), .cfg_dsm_size(cfg_dsm_size),
        .cfg_gsm_size(cfg_gsm_size), .cfg_tseg_size(cfg_tseg_size),
        .cfg_tseg_en(cfg_tseg_en), .cfg_ext_smram_en(cfg_ext_smram_en),
        .cfg_hole_en(cfg_hole_en), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_be(req_be), .req_src(req_src),
        .req_gfx_xlat(req_gfx_xlat), .req_smm(req_smm), .req_wb(req_wb),
        .out_valid(out_valid), .out_dest(out_dest), .out_addr(out_addr),
        .out_be(out_be), .out_invalid(out_invalid)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Expected result computed from the requirements
    task automatic send_and_check(input logic [35:0] a, input logic [1:0] s,
                                  input logic w, g, sm, wbt,
                                  input logic [35:0] base, lim);
        logic [1:0]  e_dest;
        logic [35:0] e_addr;
        logic [7:0]  e_be;
        string       tag;
        logic        in_t, in_h;
        logic [7:0]  be_in;
        be_in = 8'h5A ^ {4'h0, s, w, g};
        in_t = cfg_tseg_en && a >= base && a < lim;
        in_h = a >= 36'hF0_0000 && a < 36'h100_0000;
        e_addr = a; e_be = be_in; e_dest = 2'd0; tag = "R4";
        if (in_t) begin
            if (s == 2'd0) begin
                if (cfg_ext_smram_en && (!sm || !wbt)) begin e_dest = 2'd2; tag = "R7"; end
                else tag = "R6";
            end else begin
                e_dest = 2'd2; e_addr = 36'hC_0000; tag = "R8";
                if (w) e_be = 8'h00;
            end
            if (in_h) tag = "R10";
        end else if (in_h) begin
            if (g) tag = "R5";
            else if (cfg_hole_en) begin e_dest = 2'd1; tag = "R3"; end
            else tag = "R4";
        end
        if (!cfg_tseg_en && a >= base && a < lim) tag = "R9";

        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_src = s; req_write = w;
        req_gfx_xlat = g; req_smm = sm; req_wb = wbt; req_be = be_in;
        @(negedge clk);
        req_valid = 1'b0;
        check(out_valid === 1'b1, "R1", "out_valid", {63'd0, out_valid}, 64'd1);
        check(out_dest === e_dest && out_addr === e_addr && out_be === e_be &&
              out_invalid === (e_dest == 2'd2), tag, "dest/addr/be",
              {out_dest, out_invalid, out_be, out_addr},
              {e_dest, (e_dest == 2'd2), e_be, e_addr});
    endtask

    task automatic load_cfg(input logic [35:0] t, d, gs, ts);
        @(negedge clk);
        cfg_tolud = t; cfg_dsm_size = d; cfg_gsm_size = gs; cfg_tseg_size = ts;
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic sweep(input logic [35:0] a, input logic [35:0] base, lim);
        for (int en = 0; en < 8; en++) begin
            cfg_hole_en = en[0]; cfg_tseg_en = en[1]; cfg_ext_smram_en = en[2];
            for (int s = 0; s < 4; s++)
                for (int k = 0; k < 16; k++)
                    send_and_check(a, s[1:0], k[0], k[1], k[2], k[3], base, lim);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [35:0] a_list [8];
        logic [35:0] base_a, lim_a, base_n;
        rst_n = 1'b0; cfg_load = 1'b0;
        cfg_tolud = '0; cfg_dsm_size = '0; cfg_gsm_size = '0; cfg_tseg_size = '0;
        cfg_tseg_en = 1'b0; cfg_ext_smram_en = 1'b0; cfg_hole_en = 1'b0;
        req_valid = 1'b0; req_addr = '0; req_write = 1'b0; req_be = '0;
        req_src = '0; req_gfx_xlat = 1'b0; req_smm = 1'b0; req_wb = 1'b0;
        repeat (3) @(negedge clk);
        check(out_valid === 1'b0, "R1", "out_valid in reset", {63'd0, out_valid}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid === 1'b0, "R1", "out_valid after reset", {63'd0, out_valid}, 64'd0);

        // Configuration A: TSEG well above the hole
        lim_a  = 36'h2000_0000 - 36'h0100_0000 - 36'h0020_0000;
        base_a = lim_a - 36'h0080_0000;
        load_cfg(36'h2000_0000, 36'h0100_0000, 36'h0020_0000, 36'h0080_0000);
        a_list = '{base_a - 1, base_a, lim_a - 1, lim_a,
                   36'hEF_FFFF, 36'hF0_0000, 36'hFF_FFFF, 36'h100_0000};
        for (int i = 0; i < 8; i++) sweep(a_list[i], base_a, lim_a);

        // Idle cycle gives no output (R1)
        @(negedge clk);
        check(out_valid === 1'b0, "R1", "idle out_valid", {63'd0, out_valid}, 64'd0);

        // R2: size change without load is ignored, load takes effect next cycle
        cfg_tseg_en = 1'b1; cfg_ext_smram_en = 1'b1; cfg_hole_en = 1'b0;
        @(negedge clk);
        cfg_tseg_size = 36'h0040_0000;
        repeat (2) @(negedge clk);
        send_and_check(base_a, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, base_a, lim_a);
        check(out_invalid === 1'b1, "R2", "held window still blocks", {63'd0, out_invalid}, 64'd1);
        @(negedge clk);
        cfg_load = 1'b1;
        base_n = lim_a - 36'h0040_0000;
        @(negedge clk);
        cfg_load = 1'b0;
        send_and_check(base_a, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, base_n, lim_a);
        check(out_dest === 2'd0, "R2", "reloaded window no longer covers old base",
              {62'd0, out_dest}, 64'd0);
        send_and_check(base_n, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, base_n, lim_a);
        check(out_dest === 2'd2, "R2", "reloaded window starts at new base",
              {62'd0, out_dest}, 64'd2);

        // Configuration B: TSEG lies exactly over the hole (R10)
        load_cfg(36'h100_0000, 36'h0, 36'h0, 36'h10_0000);
        sweep(36'hEF_FFFF, 36'hF0_0000, 36'h100_0000);
        sweep(36'hF0_0000, 36'hF0_0000, 36'h100_0000);
        sweep(36'hFF_FFFF, 36'hF0_0000, 36'h100_0000);
        sweep(36'h100_0000, 36'hF0_0000, 36'h100_0000);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule